// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one block-transfer request into the address stream that memory needs. A request carries a 16-bit register mask, a base address, a load/store direction, an addressing mode and a writeback flag. The block walks the mask and issues one beat per selected register. Each beat carries a byte address and the register index, and moves under a valid/ready handshake. After the last beat it raises a one-cycle completion strobe. The strobe carries the updated base and a writeback enable.

There are four basic walking modes: increment-after, increment-before, decrement-after and decrement-before. Four stack-style aliases are also accepted. A full stack's pointer marks the last occupied word; an empty stack's pointer marks the first free word. The direction of stack growth then decides whether the alias means pre- or post-adjustment, and that choice differs for pushes (stores) and pops (loads). Whatever the mode, beats go out lowest register first, at the lowest address, in word steps of 4 bytes.

Top module: `ldm_addr_seq`

## Requirements
- R1: With n set bits in the mask and base B, the first beat's address for mode code 0 (increment-after) is B, for code 1 (increment-before) is B+4, for code 2 (decrement-after) is B-4n+4, and for code 3 (decrement-before) is B-4n.
- R2: Beats carry register indices in strictly ascending order, and each address is 4 above that of the previous beat.
- R3: Exactly one beat is issued per set mask bit, for any count from 1 to 16, and `xfer_last` is high on the final beat only.
- R4: The reported base is B+4n for the increment modes and B-4n for the decrement modes.
- R5: `done_valid` is high for exactly one cycle, the cycle after the final beat's handshake, and `done_wb_en` then equals the request's writeback flag.
- R6: For a store (`req_load`=0), alias codes map as follows: 4 (full-descending) to decrement-before, 5 (full-ascending) to increment-before, 6 (empty-descending) to decrement-after, and 7 (empty-ascending) to increment-after.
- R7: For a load (`req_load`=1), alias codes map as follows: 4 to increment-after, 5 to decrement-after, 6 to increment-before, and 7 to decrement-before.
- R8: An all-zero mask produces no beats. `done_valid` rises in the cycle after acceptance, and the reported base equals B.
- R9: While `xfer_ready` is low, the pending beat's address and index are held. `req_ready` is high only when no request is in progress, and after reset it is high with both `xfer_valid` and `done_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_mask | input | 16 | Register selection mask, bit i selects register i |
| req_base | input | 32 | Base address |
| req_load | input | 1 | 1 = load, 0 = store |
| req_mode | input | 3 | Addressing mode code (0..3 basic, 4..7 stack aliases) |
| req_wb | input | 1 | Write updated base back |
| xfer_valid | output | 1 | Beat present |
| xfer_ready | input | 1 | Beat consumed |
| xfer_addr | output | 32 | Byte address of the beat |
| xfer_reg | output | 4 | Register index of the beat |
| xfer_last | output | 1 | Final beat of the request |
| done_valid | output | 1 | One-cycle completion strobe |
| done_base | output | 32 | Updated base value |
| done_wb_en | output | 1 | Base writeback enable |

## Verification
Random masks with random bases and modes check the address arithmetic against mask counts that differ from run to run. Directed masks cover the edges. A full mask checks the 16-beat span, a lone top bit checks a single beat at the upper index, and an empty mask checks the no-beat path. Each alias is sent once as a load and once as a store with the same mask. That pairing tells a correct direction-dependent mapping apart from one that ignores the direction. A random `xfer_ready` inserts stalls, which shows that a beat holds while it waits and advances only on a handshake.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic [1:0] {
      AM_INC_AFTER  = 2'd0,
      AM_INC_BEFORE = 2'd1,
      AM_DEC_AFTER  = 2'd2,
      AM_DEC_BEFORE = 2'd3
   } walk_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;

   function automatic logic is_dec(input walk_mode_e m);
      return (m == AM_DEC_AFTER) || (m == AM_DEC_BEFORE);
   endfunction

   function automatic logic is_before(input walk_mode_e m);
      return (m == AM_INC_BEFORE) || (m == AM_DEC_BEFORE);
   endfunction

endpackage

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode
   import lsm_pkg::*;
(
   input  logic [2:0]  mode_code,
   input  logic        is_load,
   output walk_mode_e  walk
);
   // Aliases: a full stack adjusts before a push, an empty one after.
   // A pop reverses the direction and timing of the matching push.
   always_comb begin
      unique case (mode_code)
         3'd0:    walk = AM_INC_AFTER;
         3'd1:    walk = AM_INC_BEFORE;
         3'd2:    walk = AM_DEC_AFTER;
         3'd3:    walk = AM_DEC_BEFORE;
         3'd4:    walk = is_load ? AM_INC_AFTER  : AM_DEC_BEFORE;
         3'd5:    walk = is_load ? AM_DEC_AFTER  : AM_INC_BEFORE;
         3'd6:    walk = is_load ? AM_INC_BEFORE : AM_DEC_AFTER;
         default: walk = is_load ? AM_DEC_BEFORE : AM_INC_AFTER;
      endcase
   end
endmodule

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
   parameter int N     = 16,
   parameter int CNT_W = $clog2(N + 1)
) (
   input  logic [N-1:0]     vec,
   output logic [CNT_W-1:0] count
);
   always_comb begin
      count = '0;
      for (int i = 0; i < N; i++) begin
         count = count + CNT_W'(vec[i]);
      end
   end
endmodule

// File: rtl/lsm_lowest_set.sv
module lsm_lowest_set #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             only_one
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   assign only_one = ((vec & (vec - N'(1))) == '0);
endmodule

// File: rtl/lsm_span_calc.sv
module lsm_span_calc
   import lsm_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 5,
   parameter int STEP  = 4
) (
   input  logic [AW-1:0]    base,
   input  logic [CNT_W-1:0] count,
   input  walk_mode_e       walk,
   output logic [AW-1:0]    first_addr,
   output logic [AW-1:0]    final_base
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   logic [AW-1:0] span;
   logic [AW-1:0] low_end;

   assign span    = AW'(count) * STEP_V;
   assign low_end = is_dec(walk) ? (base - span) : base;

   always_comb begin
      unique case (walk)
         AM_INC_AFTER:  first_addr = base;
         AM_INC_BEFORE: first_addr = base + STEP_V;
         AM_DEC_AFTER:  first_addr = low_end + STEP_V;
         default:       first_addr = low_end;
      endcase
      final_base = is_dec(walk) ? (base - span) : (base + span);
   end
endmodule

// File: rtl/ldm_addr_seq.sv
module ldm_addr_seq
   import lsm_pkg::*;
#(
   parameter int NREG = 16,
   parameter int AW   = 32,
   parameter int STEP = 4,
   localparam int IDX_W = $clog2(NREG),
   localparam int CNT_W = $clog2(NREG + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [NREG-1:0]  req_mask,
   input  logic [AW-1:0]    req_base,
   input  logic             req_load,
   input  logic [2:0]       req_mode,
   input  logic             req_wb,
   output logic             xfer_valid,
   input  logic             xfer_ready,
   output logic [AW-1:0]    xfer_addr,
   output logic [IDX_W-1:0] xfer_reg,
   output logic             xfer_last,
   output logic             done_valid,
   output logic [AW-1:0]    done_base,
   output logic             done_wb_en
);
   generate
      if (NREG < 2) begin : g_bad_nreg
         $error("NREG must be at least 2");
      end
      if (STEP < 1 || AW < 8) begin : g_bad_geom
         $error("STEP must be positive and AW at least 8");
      end
   endgenerate

   seq_state_e      state_q;
   logic [NREG-1:0] rem_q;
   logic [AW-1:0]   addr_q;
   logic [AW-1:0]   final_q;
   logic            wb_q;

   walk_mode_e      walk;
   logic [CNT_W-1:0] mask_cnt;
   logic [AW-1:0]   first_addr;
   logic [AW-1:0]   final_base;
   logic [IDX_W-1:0] cur_idx;
   logic            cur_only;
   logic            accept;
   logic            beat_fire;

   lsm_mode_decode u_decode (
      .mode_code (req_mode),
      .is_load   (req_load),
      .walk      (walk)
   );

   lsm_popcount #(.N(NREG), .CNT_W(CNT_W)) u_count (
      .vec   (req_mask),
      .count (mask_cnt)
   );

   lsm_span_calc #(.AW(AW), .CNT_W(CNT_W), .STEP(STEP)) u_span (
      .base       (req_base),
      .count      (mask_cnt),
      .walk       (walk),
      .first_addr (first_addr),
      .final_base (final_base)
   );

   lsm_lowest_set #(.N(NREG), .IDX_W(IDX_W)) u_pick (
      .vec      (rem_q),
      .idx      (cur_idx),
      .only_one (cur_only)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_valid && req_ready;
   assign xfer_valid = (state_q == ST_XFER);
   assign beat_fire  = xfer_valid && xfer_ready;
   assign xfer_addr  = addr_q;
   assign xfer_reg   = cur_idx;
   assign xfer_last  = xfer_valid && cur_only;
   assign done_valid = (state_q == ST_DONE);
   assign done_base  = final_q;
   assign done_wb_en = done_valid && wb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         addr_q  <= '0;
         final_q <= '0;
         wb_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  rem_q   <= req_mask;
                  addr_q  <= first_addr;
                  final_q <= final_base;
                  wb_q    <= req_wb;
                  state_q <= (|req_mask) ? ST_XFER : ST_DONE;
               end
            end
            ST_XFER: begin
               if (beat_fire) begin
                  rem_q   <= rem_q & ~(NREG'(1) << cur_idx);
                  addr_q  <= addr_q + AW'(STEP);
                  if (cur_only) state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lsm_seq_checker.sv
module lsm_seq_checker #(
   parameter int AW    = 32,
   parameter int IDX_W = 4,
   parameter int STEP  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             xfer_valid,
   input logic             xfer_ready,
   input logic [AW-1:0]    xfer_addr,
   input logic [IDX_W-1:0] xfer_reg,
   input logic             xfer_last,
   input logic             done_valid
);
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready && !xfer_last) |=>
         (xfer_valid && xfer_addr == $past(xfer_addr) + AW'(STEP))); // R2

   AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready && !xfer_last) |=> (xfer_reg > $past(xfer_reg))); // R2

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready) |=>
         (xfer_valid && $stable(xfer_addr) && $stable(xfer_reg))); // R9

   AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready && xfer_last) |=> (done_valid && !xfer_valid)); // R5

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid); // R5

   AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready, xfer_valid, done_valid})); // R9
endmodule

bind ldm_addr_seq lsm_seq_checker #(.AW(AW), .IDX_W(IDX_W), .STEP(STEP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .xfer_valid (xfer_valid),
   .xfer_ready (xfer_ready),
   .xfer_addr  (xfer_addr),
   .xfer_reg   (xfer_reg),
   .xfer_last  (xfer_last),
   .done_valid (done_valid)
);

// File: tb/ldm_addr_seq_tb.sv
module ldm_addr_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_mask = '0;
   logic [31:0] req_base = '0;
   logic        req_load = 1'b0;
   logic [2:0]  req_mode = '0;
   logic        req_wb = 1'b0;
   logic        xfer_valid;
   logic        xfer_ready = 1'b0;
   logic [31:0] xfer_addr;
   logic [3:0]  xfer_reg;
   logic        xfer_last;
   logic        done_valid;
   logic [31:0] done_base;
   logic        done_wb_en;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ldm_addr_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_mask(req_mask), .req_base(req_base), .req_load(req_load),
      .req_mode(req_mode), .req_wb(req_wb),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
      .xfer_addr(xfer_addr), .xfer_reg(xfer_reg), .xfer_last(xfer_last),
      .done_valid(done_valid), .done_base(done_base), .done_wb_en(done_wb_en)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // 0 IA, 1 IB, 2 DA, 3 DB
   function automatic int basic_mode(input logic [2:0] m, input logic ld);
      case (m)
         3'd4: return ld ? 0 : 3;
         3'd5: return ld ? 2 : 1;
         3'd6: return ld ? 1 : 2;
         3'd7: return ld ? 3 : 0;
         default: return int'(m);
      endcase
   endfunction

   function automatic int popc(input logic [15:0] v);
      int c = 0;
      for (int i = 0; i < 16; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic int lowest(input logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return i;
      return 0;
   endfunction

   task automatic run_op(input logic [15:0] mask, input logic [31:0] base,
                         input logic ld, input logic [2:0] mode, input logic wb);
      int bm = basic_mode(mode, ld);
      int n = popc(mask);
      logic [31:0] span = 32'(4 * n);
      logic [31:0] exp_addr;
      logic [31:0] exp_final;
      logic [15:0] rem = mask;
      int beats = 0;
      bit first = 1'b1;
      bit seen_done = 1'b0;
      string tag1;
      tag1 = (mode >= 3'd4) ? (ld ? "R7" : "R6") : "R1";
      case (bm)
         0: exp_addr = base;
         1: exp_addr = base + 32'd4;
         2: exp_addr = base - span + 32'd4;
         default: exp_addr = base - span;
      endcase
      exp_final = (bm >= 2) ? base - span : base + span;

      @(negedge clk);
      req_mask = mask; req_base = base; req_load = ld; req_mode = mode; req_wb = wb;
      req_valid = 1'b1;
      check("R9 ready while idle", 32'(req_ready), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 400; k++) begin
         if (done_valid) begin
            check(mask == 0 ? "R8 done base" : "R4 done base", done_base, exp_final);
            check("R5 wb enable", 32'(done_wb_en), 32'(wb));
            check("R3 beat count", 32'(beats), 32'(n));
            if (mask == 0) check("R8 done right after accept", 32'(k), 32'd0);
            seen_done = 1'b1;
            xfer_ready = 1'b0;
            @(negedge clk);
            check("R5 done one cycle", 32'(done_valid), 32'd0);
            break;
         end
         check("R9 ready low while busy", 32'(req_ready), 32'd0);
         if (xfer_valid) begin
            check(first ? tag1 : "R2 address", xfer_addr, exp_addr);
            check("R2 register index", 32'(xfer_reg), 32'(lowest(rem)));
            check("R3 last flag", 32'(xfer_last), 32'(popc(rem) == 1));
            if (($urandom % 4) != 0) begin
               xfer_ready = 1'b1;
               rem[lowest(rem)] = 1'b0;
               exp_addr = exp_addr + 32'd4;
               beats++;
               first = 1'b0;
            end else begin
               xfer_ready = 1'b0;
            end
         end else begin
            xfer_ready = 1'b0;
         end
         @(negedge clk);
      end
      if (!seen_done) check("R5 completion seen", 32'd0, 32'd1);
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset ready", 32'(req_ready), 32'd1);
      check("R9 reset xfer_valid", 32'(xfer_valid), 32'd0);
      check("R9 reset done_valid", 32'(done_valid), 32'd0);

      // directed corners
      run_op(16'hFFFF, 32'h0000_1000, 1'b0, 3'd0, 1'b1);
      run_op(16'h8000, 32'h0000_2000, 1'b1, 3'd3, 1'b0);
      run_op(16'h0000, 32'h0000_3000, 1'b0, 3'd2, 1'b1);
      for (int m = 0; m < 4; m++) begin
         run_op(16'h40A5, 32'h0000_8000, 1'b0, 3'(4 + m), 1'b1);
         run_op(16'h40A5, 32'h0000_8000, 1'b1, 3'(4 + m), 1'b1);
      end
      for (int m = 0; m < 4; m++) run_op(16'h0001, 32'h0000_0100, 1'b1, 3'(m), 1'b1);

      // random
      for (int t = 0; t < 200; t++) begin
         logic [15:0] mk = 16'($urandom);
         if (t % 7 == 0) mk = 16'(1) << ($urandom % 16);
         run_op(mk, {$urandom % 32'h0010_0000, 2'b00} + 32'h0100_0000,
                1'($urandom), 3'($urandom), 1'($urandom));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule